// File: doc/BRIEF.md
# Double-Buffered Crosspoint Connection Map

This block keeps the routing map of a 34-output by 34-input crosspoint switch. Software reaches it through a plain register port with an 8-bit address, 8-bit write data and a combinational read path. Each output has its own staging register, which holds the number of the input routed to that output. A second, active copy of the map drives one mux-select field per output.

A two-bit commit mode sets when the active copy takes the staged one. In live mode the active copy follows every staged write. In soft-commit mode a write to the commit address copies the whole map in one cycle. In pin-commit mode a rising edge on an external commit pin does the copy, after that pin passes through a two-stage synchronizer.

A hardware reset clears both copies, so input 0 is broadcast to every output. A guarded software reset does the same. It is entered only through an unlock sequence of two writes, and it stays in force until a further write to its register.

Top module: `xbar_map`

## Requirements
- R1: After hardware reset every mux-select field is 0. Every staging address 00h–21h reads 0, the mode register (E9h) reads 0, and the software-reset register (EFh) reads 0.
- R2: With mode bits [1:0] at E9h equal to 00 or 11 (live), a write of value v to staging address k sets mux-select field k (bits k*6 to k*6+5 of `muxSel`) to v at the same clock edge that stores the write.
- R3: With mode 01 (soft commit), staging writes leave `muxSel` unchanged. A write of any data to address E8h copies all 34 staged entries into the active map at that edge.
- R4: With mode 10 (pin commit), a write to E8h has no effect. A rising edge of `commitPin` updates all 34 active entries at once, on the third rising clock edge after the pin goes high, and not before.
- R5: Reads of addresses 00h–21h return the staged value, including while it differs from the active value.
- R6: Two consecutive writes of 01h to EFh enter software reset. From the next edge on, both maps and the mode are cleared. EFh reads 01h while the reset is held, and writes to other addresses are ignored. Any later write to EFh releases the reset, and EFh then reads 00h.
- R7: If the write that follows a 01h write to EFh is not a 01h write to EFh, whether another value to EFh or a write to another address, no software reset occurs and the unlock sequence starts over. A write to another address still takes effect.
- R8: A staged value above 33 is stored and read back as written, but its mux-select field is forced to 0.
- R9: The mode register at E9h stores bits [1:0] of the written data and reads back as that value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| wrEn | input | 1 | Register write strobe for this cycle |
| addr | input | 8 | Register address for both read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| commitPin | input | 1 | Asynchronous hardware commit pin |
| muxSel | output | 204 | 34 mux-select fields of 6 bits, output k in bits k*6 to k*6+5 |

## Verification
The bench sweeps all 34 outputs in each commit mode and computes the expected selects arithmetically. A block that copied one entry per cycle, or let staged values leak through in soft or pin mode, shows stale or early fields. The pin latency is sampled edge by edge, so an extra or missing synchronizer stage is caught. The unlock sequence is broken both with a wrong value and with an intervening write. A guard that counted only EFh writes would then enter reset and wipe the map. Out-of-range values are checked at 34, 40 and 255 against the boundary value 33, which catches a clamp that is missing or off by one.

// File: rtl/xbar_map_pkg.sv
package xbar_map_pkg;
  typedef enum logic [1:0] {
    MODE_LIVE = 2'b00,
    MODE_SOFT = 2'b01,
    MODE_PIN  = 2'b10,
    MODE_ALT  = 2'b11
  } commitMode_t;

  typedef enum logic [1:0] {
    RST_IDLE  = 2'b00,
    RST_ARMED = 2'b01,
    RST_HELD  = 2'b10
  } swRstState_t;

  typedef struct packed {
    logic stageWr;
    logic follow;
    logic commitAll;
    logic clearAll;
  } mapStrobes_t;
endpackage

// File: rtl/xbar_map_ctrl.sv
module xbar_map_ctrl
  import xbar_map_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_OUT = 34,
  parameter logic [7:0] COMMIT_ADDR = 8'hE8,
  parameter logic [7:0] MODE_ADDR = 8'hE9,
  parameter logic [7:0] SWRST_ADDR = 8'hEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              commitPin,
  output mapStrobes_t       strobes,
  output commitMode_t       modeQ,
  output logic              swRstHeld
);
  localparam logic [DATA_W-1:0] UNLOCK = DATA_W'(1);

  swRstState_t rstState;
  logic pinMeta, pinSync, pinLast, pinRise;
  logic isStage, writeOk, hitCommit, hitMode, hitSwRst;

  assign isStage   = addr < ADDR_W'(NUM_OUT);
  assign hitCommit = addr == ADDR_W'(COMMIT_ADDR);
  assign hitMode   = addr == ADDR_W'(MODE_ADDR);
  assign hitSwRst  = addr == ADDR_W'(SWRST_ADDR);
  assign swRstHeld = rstState == RST_HELD;
  assign writeOk   = wrEn && !swRstHeld;
  assign pinRise   = pinSync && !pinLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= 1'b0;
      pinSync <= 1'b0;
      pinLast <= 1'b0;
    end else begin
      pinMeta <= commitPin;
      pinSync <= pinMeta;
      pinLast <= pinSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_LIVE;
    else if (swRstHeld) modeQ <= MODE_LIVE;
    else if (writeOk && hitMode) modeQ <= commitMode_t'(wrData[1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstState <= RST_IDLE;
    else if (wrEn) begin
      case (rstState)
        RST_IDLE:  rstState <= (hitSwRst && wrData == UNLOCK) ? RST_ARMED : RST_IDLE;
        RST_ARMED: rstState <= (hitSwRst && wrData == UNLOCK) ? RST_HELD : RST_IDLE;
        RST_HELD:  rstState <= hitSwRst ? RST_IDLE : RST_HELD;
        default:   rstState <= RST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.stageWr   = writeOk && isStage;
    strobes.clearAll  = swRstHeld;
    strobes.follow    = !swRstHeld && (modeQ == MODE_LIVE || modeQ == MODE_ALT);
    strobes.commitAll = !swRstHeld &&
                        ((modeQ == MODE_SOFT && writeOk && hitCommit) ||
                         (modeQ == MODE_PIN && pinRise));
  end

  // R7: a non-unlock write while armed drops the sequence
  a_r7_break_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (rstState == RST_ARMED && wrEn && !hitSwRst) |=> rstState == RST_IDLE);
  // R6: held reset forces the mode back to live
  a_r6_mode_cleared: assert property (@(posedge clk) disable iff (!rstN)
    swRstHeld |=> modeQ == MODE_LIVE);
  // R4: a pin commit needs the synchronized pin to have been low then high
  a_r4_pin_edge: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitAll && modeQ == MODE_PIN) |-> (pinSync && $past(!pinSync)));
endmodule

// File: rtl/xbar_map_store.sv
module xbar_map_store
  import xbar_map_pkg::*;
#(
  parameter int NUM_OUT = 34,
  parameter int NUM_IN = 34,
  parameter int DATA_W = 8,
  parameter int IDX_W = 6,
  parameter int SEL_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mapStrobes_t              strobes,
  input  logic [IDX_W-1:0]         stageIdx,
  input  logic [DATA_W-1:0]        stageData,
  input  logic [IDX_W-1:0]         rdIdx,
  output logic [DATA_W-1:0]        rdStage,
  output logic [NUM_OUT*SEL_W-1:0] muxSel
);
  logic [NUM_OUT-1:0][DATA_W-1:0] stagedQ, stagedNext, activeQ;

  always_comb begin
    stagedNext = stagedQ;
    if (strobes.stageWr) stagedNext[stageIdx] = stageData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedQ <= '0;
      activeQ <= '0;
    end else if (strobes.clearAll) begin
      stagedQ <= '0;
      activeQ <= '0;
    end else begin
      stagedQ <= stagedNext;
      if (strobes.follow) activeQ <= stagedNext;
      else if (strobes.commitAll) activeQ <= stagedQ;
    end
  end

  assign rdStage = stagedQ[rdIdx];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_sel
    assign muxSel[g*SEL_W +: SEL_W] =
      (activeQ[g] < DATA_W'(NUM_IN)) ? activeQ[g][SEL_W-1:0] : '0;
    // R8: a select field never names a missing input
    a_r8_sel_range: assert property (@(posedge clk) disable iff (!rstN)
      muxSel[g*SEL_W +: SEL_W] < SEL_W'(NUM_IN));
  end

  // R6: clearing empties both copies of the map
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (stagedQ == '0 && activeQ == '0));
  // R2: live mode keeps the active copy equal to the staged copy
  a_r2_follow: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.follow && !strobes.clearAll) |=> activeQ == stagedQ);
  // R3: a commit copies the whole staged map seen at the commit edge
  a_r3_commit: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitAll && !strobes.follow && !strobes.clearAll) |=> activeQ == $past(stagedQ));
  // R3: without follow, commit or clear the active copy holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.follow && !strobes.commitAll && !strobes.clearAll) |=> $stable(activeQ));
endmodule

// File: rtl/xbar_map.sv
module xbar_map
  import xbar_map_pkg::*;
#(
  parameter int NUM_OUT = 34,
  parameter int NUM_IN = 34,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_OUT),
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     commitPin,
  output logic [NUM_OUT*SEL_W-1:0] muxSel
);
  localparam logic [7:0] MODE_ADDR = 8'hE9;
  localparam logic [7:0] SWRST_ADDR = 8'hEF;

  mapStrobes_t strobes;
  commitMode_t modeQ;
  logic swRstHeld;
  logic [DATA_W-1:0] rdStage;

  xbar_map_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT),
    .COMMIT_ADDR(8'hE8), .MODE_ADDR(MODE_ADDR), .SWRST_ADDR(SWRST_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .commitPin(commitPin), .strobes(strobes), .modeQ(modeQ), .swRstHeld(swRstHeld)
  );

  xbar_map_store #(
    .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .stageIdx(addr[IDX_W-1:0]), .stageData(wrData),
    .rdIdx(addr[IDX_W-1:0]), .rdStage(rdStage), .muxSel(muxSel)
  );

  always_comb begin
    if (addr < ADDR_W'(NUM_OUT)) rdData = rdStage;
    else if (addr == ADDR_W'(MODE_ADDR)) rdData = DATA_W'(modeQ);
    else if (addr == ADDR_W'(SWRST_ADDR)) rdData = DATA_W'(swRstHeld);
    else rdData = '0;
  end
endmodule

// File: tb/xbar_map_tb.sv
`timescale 1ns/1ps
module xbar_map_tb;
  localparam int NO = 34;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic commitPin = 1'b0;
  logic [NO*SW-1:0] muxSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int expAct[NO];
  int expStg[NO];

  always #2 clk = ~clk;

  xbar_map u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .commitPin(commitPin), .muxSel(muxSel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 8'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int selOf(input int k);
    return int'(muxSel[k*SW +: SW]);
  endfunction

  function automatic int clampOf(input int v);
    return (v > 33) ? 0 : v;
  endfunction

  task automatic rd(input int a, output int v);
    addr = 8'(a);
    #0.5;
    v = int'(rdData);
  endtask

  task automatic chkAllSel(input string req);
    for (int k = 0; k < NO; k++) chk(req, selOf(k), clampOf(expAct[k]));
  endtask

  task automatic chkAllStg(input string req);
    int v;
    for (int k = 0; k < NO; k++) begin
      rd(k, v);
      chk(req, v, expStg[k]);
    end
  endtask

  initial begin
    int v;
    for (int k = 0; k < NO; k++) begin expAct[k] = 0; expStg[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkAllSel("R1 sel");
    chkAllStg("R1 staged");
    rd(8'hE9, v); chk("R1 mode", v, 0);
    rd(8'hEF, v); chk("R1 swrst", v, 0);

    // R2 live mode, full sweep
    for (int k = 0; k < NO; k++) begin
      wr(k, (k*5+7) % 34);
      expStg[k] = (k*5+7) % 34; expAct[k] = expStg[k];
      chk("R2 live sel", selOf(k), expAct[k]);
    end
    chkAllStg("R2 staged");
    wr(8'hE9, 3); rd(8'hE9, v); chk("R9 mode 11", v, 3);
    wr(0, 9); expStg[0] = 9; expAct[0] = 9;
    chk("R2 mode 11 live", selOf(0), 9);

    // R3 soft commit
    wr(8'hE9, 8'hFD); rd(8'hE9, v); chk("R9 mode bits", v, 1);
    for (int k = 0; k < NO; k++) begin
      wr(k, (k*11+1) % 34); expStg[k] = (k*11+1) % 34;
    end
    chkAllSel("R3 no early change");
    chkAllStg("R5 staged read");
    wr(8'hE8, 0);
    for (int k = 0; k < NO; k++) expAct[k] = expStg[k];
    chkAllSel("R3 commit");

    // R4 pin commit
    wr(8'hE9, 2); rd(8'hE9, v); chk("R9 mode 10", v, 2);
    for (int k = 0; k < NO; k++) begin
      wr(k, (k*3+2) % 34); expStg[k] = (k*3+2) % 34;
    end
    wr(8'hE8, 0);
    chkAllSel("R4 soft strobe ignored");
    @(negedge clk); commitPin = 1'b1;
    @(negedge clk); chkAllSel("R4 edge1");
    @(negedge clk); chkAllSel("R4 edge2");
    @(negedge clk);
    for (int k = 0; k < NO; k++) expAct[k] = expStg[k];
    chkAllSel("R4 edge3");
    repeat (4) @(negedge clk); commitPin = 1'b0;
    repeat (4) @(negedge clk);

    // R8 out of range
    wr(8'hE9, 0);
    for (int k = 0; k < NO; k++) expAct[k] = expStg[k];
    wr(5, 40); expStg[5] = 40; expAct[5] = 40;
    rd(5, v); chk("R8 stored 40", v, 40); chk("R8 sel 40", selOf(5), 0);
    wr(5, 33); chk("R8 sel 33", selOf(5), 33);
    wr(5, 34); chk("R8 sel 34", selOf(5), 0);
    wr(5, 255); expStg[5] = 255; expAct[5] = 255;
    rd(5, v); chk("R8 stored 255", v, 255); chk("R8 sel 255", selOf(5), 0);

    // R7 broken unlock
    wr(8'hEF, 1); wr(8'hEF, 2);
    @(negedge clk);
    rd(8'hEF, v); chk("R7 wrong value", v, 0);
    chkAllSel("R7 map kept");
    wr(8'hEF, 1); wr(0, 4); expStg[0] = 4; expAct[0] = 4; wr(8'hEF, 1);
    @(negedge clk);
    rd(8'hEF, v); chk("R7 interleave", v, 0);
    chk("R7 other write applied", selOf(0), 4);
    chkAllStg("R7 staged kept");

    // R6 software reset
    wr(8'hE9, 1);
    wr(8'hEF, 1); wr(8'hEF, 1);
    @(negedge clk);
    for (int k = 0; k < NO; k++) begin expAct[k] = 0; expStg[k] = 0; end
    rd(8'hEF, v); chk("R6 held", v, 1);
    chkAllSel("R6 sel cleared");
    chkAllStg("R6 staged cleared");
    rd(8'hE9, v); chk("R6 mode cleared", v, 0);
    wr(3, 12); rd(3, v); chk("R6 write ignored", v, 0);
    chk("R6 sel ignored", selOf(3), 0);
    wr(8'hEF, 0);
    rd(8'hEF, v); chk("R6 released", v, 0);
    wr(3, 12); chk("R6 live after release", selOf(3), 12);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule